// File: doc/BRIEF.md
# Multi-Channel Memory-to-Memory DMA Engine

This block is a register-programmed copy engine with six independent channels. Software sets up each channel through a 32-bit register port. The setup covers a source address, a destination address, a transfer count in units, and a command word that selects the unit size and whether each address advances. A global control word can enable the whole engine or stop it. Once a channel is enabled, the engine copies data one unit at a time through a simple master port. Each unit is read from the source and then written to the destination.

Channels that are ready to run share the master port in round-robin order, with one unit per grant. The transfer count counts down as each unit completes, so software can read the residue at any time. When the count reaches zero, the channel raises its done flag. It also raises its pending-interrupt bit if that channel's interrupt is enabled. A misaligned address stops the channel before any bus traffic and is flagged in both the channel status and the global control word.

Top module: `mcdma_top`

## Requirements
- R1: Channel i's register group sits at byte address i*0x20. The offsets are: source address +0x00, destination +0x04, count +0x08, request type +0x0C, status +0x10, command +0x14, link address +0x18. Each reads back as written, except that status keeps only bits 0, 1, 2, 3, 4, 6 and 31. An address with bits 1:0 nonzero, or any unmapped address, reads zero.
- R2: Command bits 10:8 select the unit size: 0 = 4 bytes, 1 = 1 byte, 2 = 2 bytes, 3 = 16 bytes, 4 = 32 bytes. A 16-byte unit moves as 4 word beats and a 32-byte unit as 8 word beats. memSize gives the beat size as log2 of its bytes (0, 1 or 2).
- R3: Every beat is a read of the source followed by a write of the same data to the destination. A request, together with its address and direction, is held until memAck.
- R4: Command bit 23 makes the source address advance by the unit size after each unit, and bit 22 does the same for the destination. With the bit set, beat k of a multi-beat unit uses base+4k. With the bit clear, every access uses the base address.
- R5: The count register holds units still to move. It decrements when the last beat of each unit is written, and reading it gives the live residue.
- R6: When the count reaches zero, status bit 3 (done) and bit 1 (terminated) are set and the channel stops. A channel enabled with a count of zero sets both bits without any bus access.
- R7: A channel runs only when status bit 0 is set, global control bit 0 is set, status bit 2 is clear and global bit 3 is clear. A set status bit 3 or bit 4 also holds it. A halt takes effect at the next unit boundary.
- R8: If the source or destination address is not a multiple of the unit size, the channel sets status bit 4 and bit 2 and global bit 2. It makes no bus access and leaves its count unchanged.
- R9: Bit i of the word at 0x304 is status bit 3 of channel i ANDed with command bit 1. irq is the OR of those bits, and writing status bit 3 to zero clears the bit.
- R10: Ready channels are granted in round-robin order starting after the last granted channel, with one unit per grant.
- R11: The global control word at 0x300 keeps bits 0, 2, 3 and 9:8 as written. The words at 0x308 and 0x30C read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 10 | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational from regAddr) |
| memReq | output | 1 | Master access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Master byte address |
| memSize | output | 2 | Beat size, log2 bytes |
| memWrData | output | 32 | Write data |
| memRdData | input | 32 | Read data, valid with memAck on a read |
| memAck | input | 1 | Access completes in this cycle |
| irq | output | 1 | OR of pending channel interrupts |

## Verification
The assertions check four rules on every cycle: a request stays stable until it is acknowledged, a write starts only right after an acknowledged read, beat addresses are aligned to the beat size, and a new unit starts only when the engine was enabled and not halted. Other behaviours only show up in the scenarios. These are the exact write sequence under each unit size and increment setting, the residue seen after a mid-run halt, and round-robin interleaving. They also include done, terminate and address-error flags, and interrupt gating by the command bit.

// File: rtl/mcdma_pkg.sv
package mcdma_pkg;
  localparam int DW    = 32;
  localparam int BEATW = 3;

  // register offsets inside a channel group (address bits 4:2)
  localparam logic [2:0] OFS_SRC  = 3'd0;
  localparam logic [2:0] OFS_DST  = 3'd1;
  localparam logic [2:0] OFS_CNT  = 3'd2;
  localparam logic [2:0] OFS_REQ  = 3'd3;
  localparam logic [2:0] OFS_STS  = 3'd4;
  localparam logic [2:0] OFS_CMD  = 3'd5;
  localparam logic [2:0] OFS_LINK = 3'd6;

  // channel status bits
  localparam int ST_EN   = 0;
  localparam int ST_TERM = 1;
  localparam int ST_HALT = 2;
  localparam int ST_DONE = 3;
  localparam int ST_AERR = 4;
  localparam logic [DW-1:0] STS_MASK = 32'h8000_005F;

  // command bits
  localparam int CMD_SINC = 23;
  localparam int CMD_DINC = 22;
  localparam int CMD_SZ   = 8;
  localparam int CMD_IRQ  = 1;

  // global control bits
  localparam int G_EN   = 0;
  localparam int G_AERR = 2;
  localparam int G_HALT = 3;
  localparam logic [DW-1:0] GLB_MASK = 32'h0000_030D;

  typedef struct packed {
    logic captureRd;
    logic unitDone;
    logic markDone;
    logic markAddrErr;
  } ctlStrobe_t;

  typedef struct packed {
    logic [DW-1:0] srcAddr;
    logic [DW-1:0] dstAddr;
    logic [DW-1:0] count;
    logic [2:0]    sizeCode;
  } chView_t;

  function automatic logic [5:0] unitBytes(input logic [2:0] code);
    case (code)
      3'd1:    return 6'd1;
      3'd2:    return 6'd2;
      3'd3:    return 6'd16;
      3'd4:    return 6'd32;
      default: return 6'd4;
    endcase
  endfunction

  function automatic logic [3:0] unitBeats(input logic [2:0] code);
    case (code)
      3'd3:    return 4'd4;
      3'd4:    return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

  function automatic logic [1:0] beatSize(input logic [2:0] code);
    case (code)
      3'd1:    return 2'd0;
      3'd2:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/mcdma_dp.sv
module mcdma_dp
  import mcdma_pkg::*;
#(
  parameter int NCH = 6,
  parameter int RAW = 10,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [RAW-1:0]    regAddr,
  input  logic [DW-1:0]     regWdata,
  output logic [DW-1:0]     regRdata,
  input  logic [CHW-1:0]    curCh,
  input  logic [BEATW-1:0]  beat,
  input  logic              writePhase,
  input  ctlStrobe_t        strobe,
  input  logic [DW-1:0]     memRdData,
  output chView_t           view,
  output logic [NCH-1:0]    chReady,
  output logic [NCH-1:0]    irqPend,
  output logic [DW-1:0]     memAddr,
  output logic [DW-1:0]     memWrData,
  output logic [1:0]        memSize,
  output logic              gEnable,
  output logic              gHalt
);
  localparam logic [RAW-1:0] CH_SPAN  = RAW'(NCH * 32);
  localparam logic [RAW-1:0] GLB_BASE = RAW'(12'h300);

  logic             addrOk, chanSpace, glbSpace, gWr;
  logic [CHW-1:0]   chIdx;
  logic [2:0]       ofs;
  logic [DW-1:0]    gCtrlQ, dataQ;
  logic [DW-1:0]    chRd   [NCH];
  logic [DW-1:0]    srcArr [NCH];
  logic [DW-1:0]    dstArr [NCH];
  logic [DW-1:0]    cntArr [NCH];
  logic [DW-1:0]    cmdArr [NCH];
  logic             curSInc, curDInc;

  assign addrOk    = (regAddr[1:0] == 2'b00);
  assign chanSpace = addrOk && (regAddr < CH_SPAN);
  assign glbSpace  = addrOk && (regAddr[RAW-1:4] == GLB_BASE[RAW-1:4]);
  assign chIdx     = regAddr[5 +: CHW];
  assign ofs       = regAddr[4:2];
  assign gWr       = regWe && glbSpace && (regAddr[3:2] == 2'd0);
  assign gEnable   = gCtrlQ[G_EN];
  assign gHalt     = gCtrlQ[G_HALT];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DW-1:0] srcQ, dstQ, cntQ, reqQ, cmdQ, linkQ, stsQ, stsNext, rdVal;
    logic [DW-1:0] srcStep, dstStep;
    logic          wrHit, mine, lastUnit;

    assign wrHit    = regWe && chanSpace && (chIdx == CHW'(i));
    assign mine     = (curCh == CHW'(i));
    assign lastUnit = mine && strobe.unitDone && (cntQ == 32'd1);
    assign srcStep  = cmdQ[CMD_SINC] ? 32'(unitBytes(cmdQ[CMD_SZ +: 3])) : '0;
    assign dstStep  = cmdQ[CMD_DINC] ? 32'(unitBytes(cmdQ[CMD_SZ +: 3])) : '0;

    always_comb begin
      stsNext = stsQ;
      if (wrHit && ofs == OFS_STS) stsNext = regWdata & STS_MASK;
      if ((mine && strobe.markDone) || lastUnit) begin
        stsNext[ST_DONE] = 1'b1;
        stsNext[ST_TERM] = 1'b1;
      end
      if (mine && strobe.markAddrErr) begin
        stsNext[ST_AERR] = 1'b1;
        stsNext[ST_HALT] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srcQ <= '0; dstQ <= '0; cntQ <= '0; reqQ <= '0;
        cmdQ <= '0; linkQ <= '0; stsQ <= '0;
      end else begin
        stsQ <= stsNext;
        if (wrHit && ofs == OFS_SRC) srcQ <= regWdata;
        else if (mine && strobe.unitDone) srcQ <= srcQ + srcStep;
        if (wrHit && ofs == OFS_DST) dstQ <= regWdata;
        else if (mine && strobe.unitDone) dstQ <= dstQ + dstStep;
        if (wrHit && ofs == OFS_CNT) cntQ <= regWdata;
        else if (mine && strobe.unitDone) cntQ <= cntQ - 32'd1;
        if (wrHit && ofs == OFS_REQ)  reqQ  <= regWdata;
        if (wrHit && ofs == OFS_CMD)  cmdQ  <= regWdata;
        if (wrHit && ofs == OFS_LINK) linkQ <= regWdata;
      end
    end

    always_comb begin
      case (ofs)
        OFS_SRC:  rdVal = srcQ;
        OFS_DST:  rdVal = dstQ;
        OFS_CNT:  rdVal = cntQ;
        OFS_REQ:  rdVal = reqQ;
        OFS_STS:  rdVal = stsQ;
        OFS_CMD:  rdVal = cmdQ;
        OFS_LINK: rdVal = linkQ;
        default:  rdVal = '0;
      endcase
    end

    assign chRd[i]    = rdVal;
    assign srcArr[i]  = srcQ;
    assign dstArr[i]  = dstQ;
    assign cntArr[i]  = cntQ;
    assign cmdArr[i]  = cmdQ;
    assign chReady[i] = stsQ[ST_EN] & ~stsQ[ST_HALT] & ~stsQ[ST_DONE] & ~stsQ[ST_AERR]
                        & gCtrlQ[G_EN] & ~gCtrlQ[G_HALT];
    assign irqPend[i] = stsQ[ST_DONE] & cmdQ[CMD_IRQ];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gCtrlQ <= '0;
      dataQ  <= '0;
    end else begin
      if (gWr) gCtrlQ <= regWdata & GLB_MASK;
      if (strobe.markAddrErr) gCtrlQ[G_AERR] <= 1'b1;
      if (strobe.captureRd) dataQ <= memRdData;
    end
  end

  always_comb begin
    regRdata = '0;
    if (chanSpace) begin
      for (int k = 0; k < NCH; k++)
        if (chIdx == CHW'(k)) regRdata = chRd[k];
    end else if (glbSpace) begin
      case (regAddr[3:2])
        2'd0:    regRdata = gCtrlQ;
        2'd1:    regRdata = DW'(irqPend);
        default: regRdata = '0;
      endcase
    end
  end

  always_comb begin
    view    = '0;
    curSInc = 1'b0;
    curDInc = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      if (curCh == CHW'(k)) begin
        view.srcAddr  = srcArr[k];
        view.dstAddr  = dstArr[k];
        view.count    = cntArr[k];
        view.sizeCode = cmdArr[k][CMD_SZ +: 3];
        curSInc       = cmdArr[k][CMD_SINC];
        curDInc       = cmdArr[k][CMD_DINC];
      end
    end
  end

  logic [DW-1:0] baseAddr, beatOfs;
  logic          useInc;
  assign baseAddr  = writePhase ? view.dstAddr : view.srcAddr;
  assign useInc    = writePhase ? curDInc : curSInc;
  assign beatOfs   = {{(DW-BEATW-2){1'b0}}, beat, 2'b00};
  assign memAddr   = baseAddr + (useInc ? beatOfs : '0);
  assign memWrData = dataQ;
  assign memSize   = beatSize(view.sizeCode);
endmodule

// File: rtl/mcdma_ctrl.sv
module mcdma_ctrl
  import mcdma_pkg::*;
#(
  parameter int NCH = 6,
  localparam int CHW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCH-1:0]   chReady,
  input  chView_t          view,
  input  logic             memAck,
  output logic [CHW-1:0]   curCh,
  output logic [BEATW-1:0] beat,
  output logic             writePhase,
  output logic             memReq,
  output ctlStrobe_t       strobe
);
  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_READ, S_WRITE} state_t;

  state_t           stQ;
  logic [CHW-1:0]   curQ, lastQ, pick;
  logic             pickValid, misaligned, lastBeat;
  logic [BEATW-1:0] beatQ;
  logic [DW-1:0]    alMask;

  always_comb begin
    pickValid = 1'b0;
    pick      = lastQ;
    for (int k = 1; k <= NCH; k++) begin
      if (!pickValid && chReady[(int'(lastQ) + k) % NCH]) begin
        pickValid = 1'b1;
        pick      = CHW'((int'(lastQ) + k) % NCH);
      end
    end
  end

  assign alMask     = 32'(unitBytes(view.sizeCode)) - 32'd1;
  assign misaligned = |((view.srcAddr | view.dstAddr) & alMask);
  assign lastBeat   = (4'(beatQ) == unitBeats(view.sizeCode) - 4'd1);

  assign curCh      = curQ;
  assign beat       = beatQ;
  assign memReq     = (stQ == S_READ) || (stQ == S_WRITE);
  assign writePhase = (stQ == S_WRITE);

  always_comb begin
    strobe = '0;
    case (stQ)
      S_EVAL: if (chReady[curQ]) begin
        if (view.count == '0) strobe.markDone = 1'b1;
        else if (misaligned)  strobe.markAddrErr = 1'b1;
      end
      S_READ:  strobe.captureRd = memAck;
      S_WRITE: strobe.unitDone  = memAck && lastBeat;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ   <= S_IDLE;
      curQ  <= '0;
      lastQ <= CHW'(NCH - 1);
      beatQ <= '0;
    end else begin
      case (stQ)
        S_IDLE: if (pickValid) begin
          curQ  <= pick;
          lastQ <= pick;
          stQ   <= S_EVAL;
        end
        S_EVAL: begin
          beatQ <= '0;
          if (chReady[curQ] && view.count != '0 && !misaligned) stQ <= S_READ;
          else stQ <= S_IDLE;
        end
        S_READ: if (memAck) stQ <= S_WRITE;
        S_WRITE: if (memAck) begin
          if (lastBeat) begin
            stQ   <= S_IDLE;
            beatQ <= '0;
          end else begin
            beatQ <= beatQ + 1'b1;
            stQ   <= S_READ;
          end
        end
        default: stQ <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mcdma_top.sv
module mcdma_top
  import mcdma_pkg::*;
#(
  parameter int NCH = 6,
  parameter int RAW = 10
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           regWe,
  input  logic [RAW-1:0] regAddr,
  input  logic [31:0]    regWdata,
  output logic [31:0]    regRdata,
  output logic           memReq,
  output logic           memWe,
  output logic [31:0]    memAddr,
  output logic [1:0]     memSize,
  output logic [31:0]    memWrData,
  input  logic [31:0]    memRdData,
  input  logic           memAck,
  output logic           irq
);
  localparam int CHW = $clog2(NCH);

  ctlStrobe_t       strobe;
  chView_t          view;
  logic [CHW-1:0]   curCh;
  logic [BEATW-1:0] beat;
  logic [NCH-1:0]   chReady, irqPend;
  logic             gEnable, gHalt;

  mcdma_dp #(.NCH(NCH), .RAW(RAW)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .curCh(curCh), .beat(beat),
    .writePhase(memWe), .strobe(strobe), .memRdData(memRdData), .view(view),
    .chReady(chReady), .irqPend(irqPend), .memAddr(memAddr),
    .memWrData(memWrData), .memSize(memSize), .gEnable(gEnable), .gHalt(gHalt)
  );

  mcdma_ctrl #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rstN(rstN), .chReady(chReady), .view(view), .memAck(memAck),
    .curCh(curCh), .beat(beat), .writePhase(memWe), .memReq(memReq),
    .strobe(strobe)
  );

  assign irq = |irqPend;
endmodule

// File: rtl/mcdma_chk.sv
module mcdma_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memWe,
  input logic        memAck,
  input logic [31:0] memAddr,
  input logic [1:0]  memSize,
  input logic        gEnable,
  input logic        gHalt
);
  // R3: an unacknowledged request keeps address and direction
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  // R3: a write begins only right after an acknowledged read
  assert_rd_then_wr_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && !$past(memReq && memWe) |-> $past(memAck && !memWe));

  // R8: beat addresses on the bus are aligned to the beat size
  assert_word_align_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memSize == 2'd2 |-> memAddr[1:0] == 2'b00);
  assert_half_align_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memSize == 2'd1 |-> memAddr[0] == 1'b0);

  // R7: a unit starts only while the engine is enabled and not halted
  assert_start_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !$past(memReq) |-> $past(gEnable && !gHalt));
endmodule

bind mcdma_top mcdma_chk u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .memAddr(memAddr), .memSize(memSize), .gEnable(gEnable), .gHalt(gHalt)
);

// File: tb/sim_mcdma_top.sv
`timescale 1ns/1ps
module sim_mcdma_top;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [9:0]  regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic        memReq, memWe, irq;
  logic [31:0] memAddr, memWrData;
  logic [31:0] memRdData = '0;
  logic [1:0]  memSize;
  logic        memAck = 1'b0;

  always #2 clk = ~clk;

  mcdma_top u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memSize(memSize), .memWrData(memWrData),
    .memRdData(memRdData), .memAck(memAck), .irq(irq)
  );

  int nChk = 0, nFail = 0, busCnt = 0, wrSeen = 0;
  logic [65:0] expQ[$];
  logic [65:0] e;
  logic [31:0] v;
  int mark;

  function automatic logic [31:0] memVal(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    if (rstN && memReq && !memAck) begin
      memAck <= 1'b1;
      busCnt++;
      if (!memWe) memRdData <= memVal(memAddr);
      else begin
        wrSeen++;
        if (expQ.size() == 0) check(1'b0, "R3 unexpected write", {memAddr, memWrData, memSize}, '0);
        else begin
          e = expQ.pop_front();
          check({memAddr, memWrData, memSize} == e, "R3/R4 write sequence",
                {memAddr, memWrData, memSize}, e);
        end
      end
    end else memAck <= 1'b0;
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata;
  endtask

  // R2 encoding: code -> bytes per unit / beats / beat size
  function automatic int bytesOf(input int code);
    case (code) 1: return 1; 2: return 2; 3: return 16; 4: return 32; default: return 4; endcase
  endfunction

  task automatic pushUnits(input logic [31:0] src, input logic [31:0] dst, input int cnt,
                           input int code, input bit si, input bit di);
    int nb, beats; logic [1:0] sz;
    nb = bytesOf(code);
    beats = (nb >= 4) ? nb / 4 : 1;
    sz = (nb == 1) ? 2'd0 : (nb == 2) ? 2'd1 : 2'd2;
    for (int u = 0; u < cnt; u++)
      for (int b = 0; b < beats; b++) begin
        logic [31:0] ra, wa;
        ra = src + (si ? 32'(u * nb + b * 4) : 32'd0);
        wa = dst + (di ? 32'(u * nb + b * 4) : 32'd0);
        expQ.push_back({wa, memVal(ra), sz});
      end
  endtask

  task automatic setup(input int ch, input logic [31:0] src, input logic [31:0] dst,
                       input logic [31:0] cnt, input logic [31:0] cmd);
    wr(10'(ch * 32 + 'h00), src);
    wr(10'(ch * 32 + 'h04), dst);
    wr(10'(ch * 32 + 'h08), cnt);
    wr(10'(ch * 32 + 'h14), cmd);
  endtask

  task automatic waitDone(input int ch);
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(10'(ch * 32 + 'h10), s);
      if (s[3]) break;
    end
  endtask

  function automatic logic [31:0] mkCmd(input int code, input bit si, input bit di, input bit ie);
    return (32'(si) << 23) | (32'(di) << 22) | (32'(code) << 8) | (32'(ie) << 1);
  endfunction

  task automatic finish();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    rd(10'h010, v); check(v == 0, "R1 reset status", v, 0);
    rd(10'h008, v); check(v == 0, "R5 reset count", v, 0);
    check(memReq == 0 && irq == 0, "R9 reset outputs", {memReq, irq}, 0);

    // R1 readback and status mask
    wr(10'h0AC, 32'h0000_001F); rd(10'h0AC, v); check(v == 32'h1F, "R1 request type ch5", v, 32'h1F);
    wr(10'h0B8, 32'hDEAD_BEE0); rd(10'h0B8, v); check(v == 32'hDEAD_BEE0, "R1 link ch5", v, 32'hDEAD_BEE0);
    wr(10'h0B0, 32'hFFFF_FFFF); rd(10'h0B0, v); check(v == 32'h8000_005F, "R1 status mask", v, 32'h8000_005F);
    wr(10'h0B0, 32'h0);
    rd(10'h0A2, v); check(v == 0, "R1 unaligned read", v, 0);
    // R11 global control and doorbells
    wr(10'h300, 32'hFFFF_FFF7); rd(10'h300, v); check(v == 32'h305, "R11 global mask", v, 32'h305);
    rd(10'h308, v); check(v == 0, "R11 doorbell reads zero", v, 0);
    rd(10'h30C, v); check(v == 0, "R11 doorbell set reads zero", v, 0);
    wr(10'h300, 32'h1);

    // R2/R4/R5/R6/R9: 4-byte units, both increment
    pushUnits(32'h1000, 32'h2000, 3, 0, 1, 1);
    setup(0, 32'h1000, 32'h2000, 3, mkCmd(0, 1, 1, 1));
    wr(10'h010, 32'h1);
    waitDone(0);
    rd(10'h008, v); check(v == 0, "R5 residue zero", v, 0);
    rd(10'h010, v); check(v == 32'hB, "R6 done+term", v, 32'hB);
    rd(10'h000, v); check(v == 32'h100C, "R4 source advanced", v, 32'h100C);
    rd(10'h304, v); check(v == 32'h1, "R9 pending bit0", v, 1);
    check(irq == 1, "R9 irq high", irq, 1);
    wr(10'h010, 32'h0);
    rd(10'h304, v); check(v == 0, "R9 pending cleared", v, 0);
    check(irq == 0, "R9 irq low", irq, 0);

    // R2/R4: byte units, fixed source
    pushUnits(32'h3001, 32'h4005, 2, 1, 0, 1);
    setup(1, 32'h3001, 32'h4005, 2, mkCmd(1, 0, 1, 1));
    wr(10'h030, 32'h1);
    waitDone(1);
    wr(10'h030, 32'h0);

    // R2/R4: 16-byte units, fixed destination
    pushUnits(32'h5000, 32'h6000, 2, 3, 1, 0);
    setup(2, 32'h5000, 32'h6000, 2, mkCmd(3, 1, 0, 1));
    wr(10'h050, 32'h1);
    waitDone(2);
    rd(10'h040, v); check(v == 32'h5020, "R4 16-byte source step", v, 32'h5020);
    rd(10'h044, v); check(v == 32'h6000, "R4 fixed destination", v, 32'h6000);
    wr(10'h050, 32'h0);

    // R8: misaligned source
    mark = busCnt;
    setup(3, 32'h7002, 32'h7100, 4, mkCmd(0, 1, 1, 1));
    wr(10'h070, 32'h1);
    repeat (10) @(negedge clk);
    rd(10'h070, v); check(v == 32'h15, "R8 status err+halt", v, 32'h15);
    rd(10'h300, v); check(v == 32'h5, "R8 global error", v, 32'h5);
    rd(10'h068, v); check(v == 4, "R8 count kept", v, 4);
    check(busCnt == mark, "R8 no bus access", busCnt, mark);
    wr(10'h300, 32'h1);
    wr(10'h070, 32'h0);

    // R7/R5: global gating and mid-run halt
    wr(10'h300, 32'h0);
    pushUnits(32'h8800, 32'h8900, 2, 0, 1, 1);
    setup(4, 32'h8800, 32'h8900, 2, mkCmd(0, 1, 1, 1));
    wr(10'h090, 32'h1);
    mark = busCnt;
    repeat (40) @(negedge clk);
    check(busCnt == mark, "R7 global disable blocks", busCnt, mark);
    mark = wrSeen;
    wr(10'h300, 32'h1);
    wait (wrSeen == mark + 1);
    wr(10'h300, 32'h9);
    repeat (5) @(negedge clk);
    mark = busCnt;
    repeat (40) @(negedge clk);
    check(busCnt == mark, "R7 global halt blocks", busCnt, mark);
    rd(10'h088, v); check(v == 1, "R5 live residue", v, 1);
    wr(10'h300, 32'h1);
    waitDone(4);
    rd(10'h088, v); check(v == 0, "R5 residue after resume", v, 0);
    wr(10'h090, 32'h0);

    // R6: zero count
    mark = busCnt;
    setup(5, 32'h0, 32'h0, 0, mkCmd(0, 1, 1, 1));
    wr(10'h0B0, 32'h1);
    repeat (6) @(negedge clk);
    rd(10'h0B0, v); check(v == 32'hB, "R6 zero count done", v, 32'hB);
    check(busCnt == mark, "R6 zero count no traffic", busCnt, mark);
    wr(10'h0B0, 32'h0);

    // R10: round robin between ch0 and ch2; ch2 interrupt disabled (R9)
    wr(10'h300, 32'h0);
    setup(0, 32'h8000, 32'h9000, 2, mkCmd(0, 1, 1, 1));
    setup(2, 32'hA000, 32'hB000, 2, mkCmd(0, 1, 1, 0));
    wr(10'h010, 32'h1);
    wr(10'h050, 32'h1);
    pushUnits(32'h8000, 32'h9000, 1, 0, 1, 1);
    pushUnits(32'hA000, 32'hB000, 1, 0, 1, 1);
    pushUnits(32'h8004, 32'h9004, 1, 0, 1, 1);
    pushUnits(32'hA004, 32'hB004, 1, 0, 1, 1);
    wr(10'h300, 32'h1);
    waitDone(0);
    waitDone(2);
    rd(10'h304, v); check(v == 32'h1, "R9 pending gated by command bit", v, 1);
    check(expQ.size() == 0, "R10 all expected writes seen", expQ.size(), 0);

    repeat (5) @(negedge clk);
    finish();
  end
endmodule